// File: doc/BRIEF.md
# Configurable Parallel-Prefix Adder

This block adds two N-bit operands and a carry-in, and produces an N-bit sum and a carry-out. No carry ripples from bit to bit. Each bit position forms a generate/propagate pair. A prefix network then combines these pairs with one associative carry-combine cell, so that every position holds the carry it receives. Each sum bit is the exclusive-or of its propagate and its incoming carry.

A compile-time switch chooses one of two network shapes.

- **Doubling shape.** At each level the stride doubles, and every position combines with the position one stride below it. This takes log2 N levels and N·log2 N − (N−1) cells. No node drives more than two loads.
- **Tree shape.** A reduce sweep builds block summaries upward, then a distribute sweep fills in the positions still missing. This takes 2·log2 N − 1 levels and only 2N − 2 − log2 N cells.

The carry-in is merged into the generate of bit 0 before the network, so it reaches every carry. An optional output register gives the adder one cycle of latency, for use inside a pipelined datapath. N must be a power of two.

Top module: `ppadd`

## Requirements
- R1: With the doubling shape (TREE=0), `sum` equals (a + b + cin) mod 2^N.
- R2: With the tree shape (TREE=1), `sum` equals (a + b + cin) mod 2^N.
- R3: `cout` equals bit N of the (N+1)-bit value a + b + cin, for both shapes.
- R4: When a XOR b is all ones (a full propagate chain), the carry-in passes through every bit. `sum` is all ones when cin=0 and all zeros when cin=1, and `cout` equals cin.
- R5: When a is zero, `sum` equals (b + cin) mod 2^N. `cout` is 1 only when b is all ones and cin is 1.
- R6: With REG_OUT=1, `sum` and `cout` reflect the inputs sampled at the previous rising clock edge. They hold their value between edges.
- R7: While rst_n is low, the registered `sum` and `cout` are zero, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a | input | N | First operand |
| b | input | N | Second operand |
| cin | input | 1 | Carry-in |
| sum | output | N | Sum bits |
| cout | output | 1 | Carry-out of the most significant bit |

## Verification
A wrong combine cell, or a wrong stride in one network level, breaks only the carries of the positions that cell feeds. The fault shows as a wrong sum bit at or above the affected position, together with a wrong carry-out, in the first registered cycle after a triggering operand pair. Full propagate chains and near-overflow operands make such a fault visible, because the single carry-in must travel through every level to the top bit. Both shapes are driven with the same vectors and compared against the arithmetic sum. A fault in either network therefore stands out against the other network, which still produces the correct result.

// File: rtl/ppadd.sv
module ppadd #(
  parameter int N       = 16,
  parameter bit TREE    = 1'b0,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);
  localparam int L = $clog2(N);
  localparam int S = TREE ? 2*L-1 : L;

  logic [N-1:0] p, g;
  logic [N-1:0] gs [0:S];
  logic [N-1:0] ps [0:S];
  logic [N-1:0] c, s_c;
  logic         co_c;

  assign p = a ^ b;
  assign g = a & b;
  assign gs[0] = {g[N-1:1], g[0] | (p[0] & cin)};
  assign ps[0] = p;

  genvar s, i;
  generate
    for (s = 0; s < S; s++) begin : g_lvl
      localparam int T   = (TREE && s >= L) ? (2*L-2-s) : s;
      localparam int D   = 1 << T;
      for (i = 0; i < N; i++) begin : g_pos
        localparam bit UP   = ((i + 1) % (2*D)) == 0;
        localparam bit DOWN = (((i + 1) % (2*D)) == D) && (i + 1 >= 3*D);
        localparam bit CELL = !TREE ? (i >= D) : ((s < L) ? UP : DOWN);
        if (CELL) begin : g_cell
          assign gs[s+1][i] = gs[s][i] | (ps[s][i] & gs[s][i-D]);
          assign ps[s+1][i] = ps[s][i] & ps[s][i-D];
        end else begin : g_wire
          assign gs[s+1][i] = gs[s][i];
          assign ps[s+1][i] = ps[s][i];
        end
      end
    end
  endgenerate

  assign c    = {gs[S][N-2:0], cin};
  assign s_c  = p ^ c;
  assign co_c = gs[S][N-1];

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sum  <= '0;
          cout <= 1'b0;
        end else begin
          sum  <= s_c;
          cout <= co_c;
        end
      end

      // R6: registered outputs follow the core one edge later
      assert_lat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sum == $past(s_c)) && (cout == $past(co_c)));

      assert_rst_R7: assert property (@(posedge clk)
        !rst_n |=> (sum == '0) && (cout == 1'b0));
    end else begin : g_comb
      assign sum  = s_c;
      assign cout = co_c;
    end
  endgenerate

  logic [N:0] ref_total;
  assign ref_total = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin};

  // R1 for the doubling shape, R2 for the tree shape
  assert_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
    s_c == ref_total[N-1:0]);

  assert_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    co_c == ref_total[N]);

  assert_chain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (p == '1) |-> (co_c == cin) && (s_c == {N{~cin}}));

  assert_pchain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gs[S] & ps[S]) == (ps[S] & {N{cin}}));

  assert_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (a == '0) |-> (s_c == b + {{(N-1){1'b0}}, cin}) && (co_c == ((&b) & cin)));
endmodule

// File: tb/sim_ppadd.sv
module sim_ppadd;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] a = '1, b = '1;
  logic         cin = 1'b1;
  logic [N-1:0] sum0, sum1;
  logic         cout0, cout1;

  int nchk = 0;
  int nerr = 0;
  logic [N:0] exp_q [$];
  string      tag_q [$];

  always #2 clk = ~clk;

  ppadd #(.N(N), .TREE(1'b0), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin), .sum(sum0), .cout(cout0));
  ppadd #(.N(N), .TREE(1'b1), .REG_OUT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin), .sum(sum1), .cout(cout1));

  task automatic chk(input string req, input logic [N:0] act, input logic [N:0] expv);
    nchk++;
    if (act !== expv) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [N:0] model(input logic [N-1:0] x, input logic [N-1:0] y,
                                       input logic ci);
    return {1'b0, x} + {1'b0, y} + {{N{1'b0}}, ci};
  endfunction

  task automatic drive(input logic [N-1:0] x, input logic [N-1:0] y, input logic ci,
                       input string tag);
    @(negedge clk);
    a = x; b = y; cin = ci;
    exp_q.push_back(model(x, y, ci));
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [N:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (t == "R1") begin
        chk("R1", {1'b0, sum0}, {1'b0, e[N-1:0]});
        chk("R2", {1'b0, sum1}, {1'b0, e[N-1:0]});
        chk("R3", {N'(0), cout0}, {N'(0), e[N]});
        chk("R3", {N'(0), cout1}, {N'(0), e[N]});
      end else begin
        chk(t, {cout0, sum0}, e);
        chk(t, {cout1, sum1}, e);
      end
    end
  end

  initial begin
    #100000;
    nerr++;
    nchk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R7", {cout0, sum0}, '0);
    chk("R7", {cout1, sum1}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    a = 16'd5; b = 16'd7; cin = 1'b0;
    @(posedge clk); #1;
    chk("R6", {cout0, sum0}, 17'd12);
    chk("R6", {cout1, sum1}, 17'd12);
    @(negedge clk);
    a = 16'd100; b = 16'd1;
    #1;
    chk("R6", {cout0, sum0}, 17'd12);
    chk("R6", {cout1, sum1}, 17'd12);
    @(posedge clk); #1;
    chk("R6", {cout0, sum0}, 17'd101);
    chk("R6", {cout1, sum1}, 17'd101);

    drive(16'hAAAA, 16'h5555, 1'b0, "R4");
    drive(16'hAAAA, 16'h5555, 1'b1, "R4");
    drive(16'h0000, 16'hFFFF, 1'b1, "R4");
    for (int k = 0; k < 8; k++) begin
      logic [N-1:0] r;
      r = N'($urandom);
      drive(r, ~r, k[0], "R4");
    end
    drive(16'h0000, 16'h0000, 1'b0, "R5");
    drive(16'h0000, 16'h0000, 1'b1, "R5");
    drive(16'h0000, 16'hFFFF, 1'b0, "R5");
    for (int k = 0; k < 8; k++) drive(16'h0000, N'($urandom), k[0], "R5");
    drive(16'hFFFF, 16'hFFFF, 1'b1, "R3");
    drive(16'h8000, 16'h8000, 1'b0, "R3");
    drive(16'hFFFF, 16'h0001, 1'b0, "R3");
    for (int k = 0; k < 300; k++) drive(N'($urandom), N'($urandom), 1'($urandom), "R1");
    @(negedge clk);
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule